// File: doc/BRIEF.md
# Message-Signalled Interrupt Controller

The block turns interrupt messages posted by devices into vector deliveries for CPU cores. A device posts one 32-bit word on the response bus. The word names a target controller by a 6-bit number and carries a 12-bit vector number. The block accepts a message only when the controller number matches its own ID. It queues the accepted vector in a small pending FIFO. It then reads the matching 128-bit entry from an internal block-RAM vector table and presents the whole entry on a dedicated vector bus. The bus uses a valid/ready handshake, and the target core number taken from the entry is shown beside it.

Software fills the table through a word-addressed register port. Each entry spans four 32-bit words. The table holds four operating modes of 512 entries each. Malformed messages and messages that find the queue full are dropped, and each kind of drop has its own saturating counter.

Top module: `msi_irq_ctrl`

## Requirements
- R1: A message word is decoded as vector = bits [11:0] and controller number = bits [17:12]; bits [31:18] are ignored. A message whose controller number differs from `ctrl_id_i` causes no delivery and changes no counter.
- R2: A matching message with vector bit 11 set is dropped, and `err_cnt_o` increments by one, saturating at its maximum.
- R3: Accepted vectors wait in a 16-deep FIFO. A matching, well-formed message that arrives while the FIFO is full is dropped, and `ovf_cnt_o` increments by one, saturating.
- R4: The table index is {vector[10:9] mode, vector[8:0] entry}, giving 2048 entries. The register word address is {index, word[1:0]}, where word k holds entry bits [32k+31:32k].
- R5: A register read asserts `reg_rvalid_o` in the cycle after the request and returns the addressed word on `reg_rdata_o`. A register write updates only the addressed word.
- R6: The entry layout is: [63:0] ISR address, [95:64] data word, [101:96] target core, [127] enable. `vec_core_o` shows bits [101:96] of the delivered entry.
- R7: A message whose entry has the enable bit clear is dropped without delivery.
- R8: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_valid_o` stays high and `vec_entry_o` stays unchanged.
- R9: Entries are delivered one at a time, in the order their messages were accepted.
- R10: A register access in the same cycle as a pending lookup takes the RAM port first, so a lookup returns the table contents after the write.
- R11: After reset, `vec_valid_o`, `reg_rvalid_o` and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_id_i | input | 6 | This controller's ID |
| msg_valid_i | input | 1 | Message word valid on the response bus |
| msg_data_i | input | 32 | Interrupt message word |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 13 | Word address {mode, entry, word} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| vec_valid_o | output | 1 | Vector entry valid |
| vec_ready_i | input | 1 | Core accepts the vector |
| vec_core_o | output | 6 | Target core of the presented entry |
| vec_entry_o | output | 128 | Full vector table entry |
| err_cnt_o | output | 8 | Malformed-vector drop count |
| ovf_cnt_o | output | 8 | FIFO-full drop count |

## Verification
The assertions check several rules on every cycle. The entry and valid must hold under back-pressure, and only enabled entries may reach the bus. Each kind of drop must move its counter by exactly one, and foreign messages must leave both counters alone. A read must answer in the next cycle, and a lookup must never share the RAM port with a register access. Only the bench scenarios can show that the data is correct. These scenarios cover a table readback across all four modes, deliveries that match the written entries, arrival order through a full queue, a lookup that returns the contents of a concurrent write, and disabled or foreign messages that produce nothing.

// File: rtl/msic_pkg.sv
package msic_pkg;
  localparam int unsigned ENTRY_W  = 128;
  localparam int unsigned CORE_LSB = 96;
  localparam int unsigned CORE_W   = 6;
  localparam int unsigned EN_BIT   = 127;

  typedef struct packed {
    logic [13:0] rsvd;
    logic [5:0]  ctrl;
    logic [11:0] vec;
  } irq_msg_t;
endpackage

// File: rtl/msic_ingress.sv
module msic_ingress
  import msic_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [5:0]       ctrl_id_i,
  input  logic             msg_valid_i,
  input  logic [31:0]      msg_data_i,
  input  logic             full_i,
  output logic             push_o,
  output logic [IDX_W-1:0] push_idx_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [CNT_W-1:0] ovf_cnt_o
);
  irq_msg_t msg;
  logic hit, bad, drop;
  logic unused_rsvd;

  always_comb begin
    msg        = irq_msg_t'(msg_data_i);
    hit        = msg_valid_i && (msg.ctrl == ctrl_id_i);
    bad        = hit && msg.vec[11];
    drop       = hit && !msg.vec[11] && full_i;
    push_o     = hit && !msg.vec[11] && !full_i;
    push_idx_o = msg.vec[IDX_W-1:0];
  end
  assign unused_rsvd = ^msg.rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_o <= '0;
      ovf_cnt_o <= '0;
    end else begin
      if (bad && err_cnt_o != '1) err_cnt_o <= err_cnt_o + 1'b1;
      if (drop && ovf_cnt_o != '1) ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/msic_fifo.sv
module msic_fifo #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign rdata_o = mem[rp];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_i)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/msic_vtable.sv
module msic_vtable
  import msic_pkg::*;
#(
  parameter int unsigned IDX_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [IDX_W+1:0]   reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               reg_rvalid_o,
  input  logic               lk_re_i,
  input  logic [IDX_W-1:0]   lk_idx_i,
  output logic [ENTRY_W-1:0] dout_o
);
  localparam int unsigned N = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [N];
  logic [IDX_W-1:0] addr;
  logic [1:0] wsel, rsel_q;
  logic wr, rd;

  always_comb begin
    wr   = reg_req_i && reg_we_i;
    rd   = (reg_req_i && !reg_we_i) || lk_re_i;
    addr = reg_req_i ? reg_addr_i[IDX_W+1:2] : lk_idx_i;
    wsel = reg_addr_i[1:0];
  end

  always_ff @(posedge clk_i) begin
    if (wr) mem[addr][wsel*32 +: 32] <= reg_wdata_i;
    else if (rd) dout_o <= mem[addr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      rsel_q       <= '0;
    end else begin
      reg_rvalid_o <= reg_req_i && !reg_we_i;
      if (reg_req_i) rsel_q <= wsel;
    end
  end

  assign reg_rdata_o = dout_o[rsel_q*32 +: 32];
endmodule

// File: rtl/msi_irq_ctrl.sv
module msi_irq_ctrl
  import msic_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned ENT_W      = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [5:0]           ctrl_id_i,
  input  logic                 msg_valid_i,
  input  logic [31:0]          msg_data_i,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [MODE_W+ENT_W+1:0] reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 reg_rvalid_o,
  output logic                 vec_valid_o,
  input  logic                 vec_ready_i,
  output logic [CORE_W-1:0]    vec_core_o,
  output logic [ENTRY_W-1:0]   vec_entry_o,
  output logic [CNT_W-1:0]     err_cnt_o,
  output logic [CNT_W-1:0]     ovf_cnt_o
);
  localparam int unsigned IDX_W = MODE_W + ENT_W;

  logic push, full, empty, lk_issue, lk_pend;
  logic [IDX_W-1:0] push_idx, head_idx;
  logic [ENTRY_W-1:0] dout;

  msic_ingress #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ingress (
    .clk_i, .rst_ni, .ctrl_id_i, .msg_valid_i, .msg_data_i,
    .full_i(full), .push_o(push), .push_idx_o(push_idx),
    .err_cnt_o, .ovf_cnt_o
  );

  msic_fifo #(.W(IDX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(push_idx),
    .pop_i(lk_issue), .rdata_o(head_idx), .empty_o(empty), .full_o(full)
  );

  msic_vtable #(.IDX_W(IDX_W)) u_vtable (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .reg_rvalid_o,
    .lk_re_i(lk_issue), .lk_idx_i(head_idx), .dout_o(dout)
  );

  // register port owns the RAM; one lookup in flight, none while an entry waits
  assign lk_issue = !empty && !reg_req_i && !lk_pend && !vec_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_pend     <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_entry_o <= '0;
    end else begin
      lk_pend <= lk_issue;
      if (lk_pend && dout[EN_BIT]) begin
        vec_valid_o <= 1'b1;
        vec_entry_o <= dout;
      end else if (vec_valid_o && vec_ready_i) begin
        vec_valid_o <= 1'b0;
      end
    end
  end

  assign vec_core_o = vec_entry_o[CORE_LSB +: CORE_W];
endmodule

// File: rtl/msic_chk.sv
module msic_chk
  import msic_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [5:0]         ctrl_id_i,
  input logic               msg_valid_i,
  input logic [31:0]        msg_data_i,
  input logic               reg_req_i,
  input logic               reg_we_i,
  input logic               reg_rvalid_o,
  input logic               vec_valid_o,
  input logic               vec_ready_i,
  input logic [ENTRY_W-1:0] vec_entry_o,
  input logic [CNT_W-1:0]   err_cnt_o,
  input logic [CNT_W-1:0]   ovf_cnt_o,
  input logic               lk_issue,
  input logic               full
);
  logic hit;
  assign hit = msg_valid_i && (msg_data_i[17:12] == ctrl_id_i);

  // R1
  foreign_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && !hit) |=> ($stable(err_cnt_o) && $stable(ovf_cnt_o)));
  // R2
  err_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && msg_data_i[11]) |=>
      (err_cnt_o == $past(err_cnt_o) + 1'b1 || $past(err_cnt_o) == '1));
  // R3
  ovf_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !msg_data_i[11] && full) |=>
      (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1 || $past(ovf_cnt_o) == '1));
  // R5
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i) |=> reg_rvalid_o);
  // R7
  only_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> vec_entry_o[EN_BIT]);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_entry_o)));
  // R10
  port_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i |-> !lk_issue);
endmodule

bind msi_irq_ctrl msic_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .ctrl_id_i, .msg_valid_i, .msg_data_i,
  .reg_req_i, .reg_we_i, .reg_rvalid_o, .vec_valid_o, .vec_ready_i,
  .vec_entry_o, .err_cnt_o, .ovf_cnt_o, .lk_issue(lk_issue), .full(full)
);

// File: tb/tb_msi_irq_ctrl.sv
module tb_msi_irq_ctrl;
  localparam logic [5:0] MY_ID = 6'd37;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [5:0] ctrl_id_i = MY_ID;
  logic msg_valid_i = 1'b0;
  logic [31:0] msg_data_i = '0;
  logic reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [12:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic reg_rvalid_o, vec_valid_o;
  logic vec_ready_i = 1'b1;
  logic [5:0] vec_core_o;
  logic [127:0] vec_entry_o;
  logic [7:0] err_cnt_o, ovf_cnt_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  msi_irq_ctrl dut (.*);

  function automatic logic [31:0] pat(int idx, int w);
    case (w)
      0: return 32'hA000_0000 + 32'(idx * 4);
      1: return 32'(idx) ^ 32'h5A5A_0000;
      2: return 32'(idx) * 32'h0001_0003 + 32'd7;
      default: return {1'b1, 25'd0, 6'(idx)};
    endcase
  endfunction

  function automatic logic [127:0] exp_entry(int idx);
    return {pat(idx, 3), pat(idx, 2), pat(idx, 1), pat(idx, 0)};
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int idx, int w, logic [31:0] d);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b1;
    reg_addr_i = 13'((idx << 2) | w); reg_wdata_i = d;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic reg_rd_chk(int idx, int w, logic [31:0] exp);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = 13'((idx << 2) | w);
    @(negedge clk_i);
    reg_req_i = 1'b0;
    chk(reg_rvalid_o && reg_rdata_o == exp, "R4/R5 readback", 128'(reg_rdata_o), 128'(exp));
  endtask

  task automatic send(logic [5:0] id, logic [11:0] vec);
    @(negedge clk_i);
    msg_valid_i = 1'b1;
    msg_data_i = {14'h2ABC, id, vec};  // R1: reserved bits set to noise
    @(negedge clk_i);
    msg_valid_i = 1'b0;
  endtask

  task automatic expect_vec(logic [127:0] exp, string req);
    int n = 0;
    while (!vec_valid_o && n < 40) begin @(negedge clk_i); n++; end
    chk(vec_valid_o && vec_entry_o == exp, req, vec_entry_o, exp);
    chk(vec_core_o == exp[101:96], "R6 core", 128'(vec_core_o), 128'(exp[101:96]));
    @(negedge clk_i);  // transfer happens at the edge in between
  endtask

  task automatic expect_none(int cyc, string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk_i); if (vec_valid_o) seen = 1'b1; end
    chk(!seen, req, 128'(seen), 128'(0));
  endtask

  initial begin
    int idx_list[6] = '{0, 1, 2, 255, 510, 511};
    logic [7:0] e0;
    #1;
    chk(!vec_valid_o && !reg_rvalid_o && err_cnt_o == 0 && ovf_cnt_o == 0,
        "R11 reset", {vec_valid_o, reg_rvalid_o, err_cnt_o, ovf_cnt_o}, 128'(0));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R4 R5: fill and read back across all modes
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 6; k++)
        for (int w = 0; w < 4; w++) reg_wr(m * 512 + idx_list[k], w, pat(m * 512 + idx_list[k], w));
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 6; k++)
        for (int w = 0; w < 4; w++) reg_rd_chk(m * 512 + idx_list[k], w, pat(m * 512 + idx_list[k], w));

    // R1 R4 R6: each programmed entry delivered in full
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 6; k++) begin
        send(MY_ID, 12'(m * 512 + idx_list[k]));
        expect_vec(exp_entry(m * 512 + idx_list[k]), "R4/R6 delivery");
      end

    // R1: foreign controller numbers
    send(MY_ID ^ 6'd1, 12'd1);
    send(6'd0, 12'd2);
    expect_none(12, "R1 foreign ignored");
    chk(err_cnt_o == 0 && ovf_cnt_o == 0, "R1 counters", {err_cnt_o, ovf_cnt_o}, 128'(0));

    // R2: vector bit 11 set
    send(MY_ID, 12'h801);
    send(MY_ID, 12'hFFF);
    expect_none(12, "R2 dropped");
    chk(err_cnt_o == 8'd2, "R2 err count", 128'(err_cnt_o), 128'(2));

    // R7: disabled entry dropped, next enabled one delivered
    reg_wr(2, 3, pat(2, 3) & 32'h7FFF_FFFF);
    send(MY_ID, 12'd2);
    expect_none(12, "R7 disabled");
    send(MY_ID, 12'd1);
    expect_vec(exp_entry(1), "R7 following entry");

    // R10: writes hold the port, lookup sees the written value
    for (int i = 100; i < 119; i++)
      for (int w = 0; w < 4; w++) reg_wr(i, w, pat(i, w));
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_data_i = {14'd0, MY_ID, 12'd100};
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 13'((100 << 2) | 2); reg_wdata_i = 32'h1111_1111;
    @(negedge clk_i);
    msg_valid_i = 1'b0; reg_wdata_i = 32'h2222_2222;
    @(negedge clk_i);
    reg_wdata_i = 32'hCAFE_F00D;
    @(negedge clk_i);
    reg_req_i = 1'b0; reg_we_i = 1'b0;
    begin
      logic [127:0] e = exp_entry(100);
      e[95:64] = 32'hCAFE_F00D;
      expect_vec(e, "R10 write priority");
    end
    reg_wr(100, 2, pat(100, 2));

    // R3 R8 R9: back-pressure, full queue, order
    vec_ready_i = 1'b0;
    e0 = ovf_cnt_o;
    for (int i = 0; i < 19; i++) begin
      @(negedge clk_i);
      msg_valid_i = 1'b1; msg_data_i = {14'd0, MY_ID, 12'(100 + i)};
    end
    @(negedge clk_i);
    msg_valid_i = 1'b0;
    chk(ovf_cnt_o == e0 + 8'd2, "R3 overflow count", 128'(ovf_cnt_o), 128'(e0 + 8'd2));
    repeat (5) @(negedge clk_i);
    chk(vec_valid_o && vec_entry_o == exp_entry(100), "R8 held", vec_entry_o, exp_entry(100));
    vec_ready_i = 1'b1;
    for (int i = 0; i < 17; i++) expect_vec(exp_entry(100 + i), "R9 order");
    expect_none(12, "R3 dropped not delivered");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule